// File: doc/BRIEF.md
# SCSI Controller Command Decoder

This block sits behind the host register port of a SCSI bus controller. The host writes 8-bit command bytes to it. The decoder checks each byte against the controller's current connection state, which is one of three: disconnected, connected as initiator, or connected as target. A command that is legal in the current state produces a one-cycle start pulse, together with the decoded opcode and the DMA flag, for the downstream sequencers. A command that is not legal in that state does not execute. It raises the illegal-command interrupt cause instead.

Interrupt causes come from several places: bus events reported by the bus front end, completion reports from the sequencers, and the decoder's own command handling. All of them are latched in an 8-bit interrupt status register. Reading that register returns the latched causes and clears them. The status byte carries a pending-interrupt flag in bit 7 and mirrors the three bus phase lines in its low bits.

The bus signalling, the DMA engine and the FIFO datapath are outside this block. They appear only as simple pulse inputs and outputs.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: After reset, `conn` is 0 (disconnected), `isr_q` is 0, `stat_q[7]` is 0 and `start` is low.
- R2: Legality is judged on `cmd_data[6:0]` only.
  - Opcodes 0x00 (no-op), 0x01 (FIFO flush), 0x02 (chip reset) and 0x03 (bus reset) are legal in every state.
  - Opcodes 0x40 to 0x46 are legal only in state 0 (disconnected).
  - Opcodes 0x10, 0x11, 0x12, 0x18, 0x1A and 0x1B are legal only in state 1 (initiator).
  - Opcode 0x27 (disconnect) is legal only in state 2 (target).
  - Every other opcode is illegal in every state.
- R3: A legal write makes `start` high for exactly the one cycle after the write edge. In that cycle, `op_code` equals `cmd_data[6:0]` and `op_dma` equals `cmd_data[7]`.
- R4: An illegal write sets `isr_q[6]` on the following edge. It produces no `start` pulse and leaves `conn` unchanged.
- R5: Bus events on `bus_evt` latch into `isr_q` at the same bit positions, and some of them change the connection state.
  - Bit 7 (bus reset seen) moves `conn` to 0. Its cause is latched only while `cfg_rst_irq_off` is 0.
  - Bit 5 (disconnect) moves `conn` to 0.
  - Bit 4 (bus service) changes no state.
  - Bit 2 (reselected) moves `conn` to 1.
  - Bits 1 and 0 (selected with and without ATN) move `conn` to 2.
  - Bits 6 and 3 of `bus_evt` are ignored.
- R6: Holding `isr_rd` high for one cycle returns the latched causes on `isr_q` during that cycle and clears them at the edge. `stat_q[7]` then drops in the same cycle as `isr_q`. A cause that arrives in the reading cycle stays latched.
- R7: `seq_done` acts only while a started command is outstanding.
  - It completes that command and applies `seq_conn` as the new state; the value 3 keeps the current state.
  - It sets `isr_q[3]` unless the command is one of the quiet ones: 0x00 to 0x03, 0x44, 0x1A, 0x1B or 0x27.
  - With no command outstanding, `seq_done` has no effect.
- R8: The bus reset command (0x03) moves `conn` to 0. It sets `isr_q[7]` only when `cfg_rst_irq_off` is 0.
- R9: The chip reset command (0x02) moves `conn` to 0 and clears every latched cause, and no later completion is reported for it.
- R10: The disconnect command (0x27), issued as target, moves `conn` to 0 on its write edge and raises no cause.
- R11: `stat_q[2:0]` always equals `phase_in`, and `stat_q[6:3]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte; bit 7 is the DMA flag |
| cfg_rst_irq_off | input | 1 | Suppresses the bus-reset interrupt cause |
| phase_in | input | 3 | Bus phase lines MSG, C/D, I/O |
| bus_evt | input | 8 | One-cycle bus event pulses, positioned like the status bits |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_conn | input | 2 | Connection state after completion (3 keeps the state) |
| isr_rd | input | 1 | Read-and-clear of the interrupt status |
| start | output | 1 | One-cycle start pulse for a legal command |
| op_code | output | 7 | Opcode of the started command |
| op_dma | output | 1 | DMA flag of the started command |
| conn | output | 2 | Connection state: 0 disconnected, 1 initiator, 2 target |
| isr_q | output | 8 | Latched interrupt causes |
| stat_q | output | 8 | Status: bit 7 pending, bits 2:0 bus phase |

## Verification
The main sweep writes every one of the 128 opcodes in each of the three connection states, with the DMA flag and the reset-interrupt mask varied between writes. This separates legal from illegal decoding for each state. It also separates the effect of each state-changing command from that of commands that leave the state alone.

After each legal command, a completion pulse tells the quiet commands apart from those that report a function-complete cause. Directed patterns then cover the rest:
- a read that collides with a new cause, against a plain read;
- masked bus-reset events against unmasked ones;
- ignored event bits;
- a completion with no command outstanding;
- a chip reset issued while causes are pending.

// File: rtl/scd_pkg.sv
package scd_pkg;

   typedef enum logic [1:0] {
      CONN_IDLE = 2'd0,
      CONN_INIT = 2'd1,
      CONN_TGT  = 2'd2
   } conn_e;

   // interrupt cause bit positions
   localparam int IRQ_BUSRST = 7;
   localparam int IRQ_BADCMD = 6;
   localparam int IRQ_DROP   = 5;
   localparam int IRQ_SVC    = 4;
   localparam int IRQ_DONE   = 3;
   localparam int IRQ_RESEL  = 2;
   localparam int IRQ_SELA   = 1;
   localparam int IRQ_SEL    = 0;

   // opcodes (DMA flag stripped)
   localparam logic [6:0] OP_NOP      = 7'h00;
   localparam logic [6:0] OP_FLUSH    = 7'h01;
   localparam logic [6:0] OP_CHIPRST  = 7'h02;
   localparam logic [6:0] OP_BUSRST   = 7'h03;
   localparam logic [6:0] OP_IDLE_LO  = 7'h40;
   localparam logic [6:0] OP_IDLE_HI  = 7'h46;
   localparam logic [6:0] OP_RESEL_ON = 7'h44;
   localparam logic [6:0] OP_XFER     = 7'h10;
   localparam logic [6:0] OP_CSEQ     = 7'h11;
   localparam logic [6:0] OP_MACK     = 7'h12;
   localparam logic [6:0] OP_PAD      = 7'h18;
   localparam logic [6:0] OP_ATN_SET  = 7'h1A;
   localparam logic [6:0] OP_ATN_CLR  = 7'h1B;
   localparam logic [6:0] OP_DROP     = 7'h27;

   typedef struct packed {
      logic legal;
      logic quiet;
      logic chip_rst;
      logic bus_rst;
      logic drop;
   } cmd_class_t;

endpackage

// File: rtl/scd_classify.sv
module scd_classify
   import scd_pkg::*;
#(
   parameter int OP_W = 7
) (
   input  conn_e            conn,
   input  logic [OP_W-1:0]  opc,
   output cmd_class_t       cls
);

   if (OP_W != 7) begin : g_bad_w
      $error("scd_classify: OP_W must be 7");
   end

   logic any_ok;
   logic idle_ok;
   logic init_ok;
   logic tgt_ok;

   always_comb begin
      any_ok  = (opc <= OP_BUSRST);
      idle_ok = (opc >= OP_IDLE_LO) && (opc <= OP_IDLE_HI);
      unique case (opc)
         OP_XFER, OP_CSEQ, OP_MACK, OP_PAD, OP_ATN_SET, OP_ATN_CLR: init_ok = 1'b1;
         default: init_ok = 1'b0;
      endcase
      tgt_ok = (opc == OP_DROP);

      cls.legal    = any_ok
                   | ((conn == CONN_IDLE) & idle_ok)
                   | ((conn == CONN_INIT) & init_ok)
                   | ((conn == CONN_TGT)  & tgt_ok);
      cls.quiet    = any_ok | (opc == OP_RESEL_ON) | (opc == OP_ATN_SET)
                   | (opc == OP_ATN_CLR) | (opc == OP_DROP);
      cls.chip_rst = (opc == OP_CHIPRST);
      cls.bus_rst  = (opc == OP_BUSRST);
      cls.drop     = (opc == OP_DROP);
   end

endmodule

// File: rtl/scd_isr.sv
module scd_isr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic         rd,
   input  logic [W-1:0] set_vec,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("scd_isr: W must be positive");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n || clr_all) begin
            q[b] <= 1'b0;
         end else begin
            q[b] <= (q[b] & ~rd) | set_vec[b];
         end
      end
   end

endmodule

// File: rtl/scd_conn.sv
module scd_conn
   import scd_pkg::*;
#(
   parameter int EVT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  cmd_class_t       cls,
   input  logic [EVT_W-1:0] bus_evt,
   input  logic             seq_apply,
   input  logic [1:0]       seq_conn,
   output conn_e            conn
);

   localparam logic [1:0] KEEP = 2'd3;

   conn_e nxt;

   always_comb begin
      nxt = conn;
      if (fire && (cls.chip_rst || cls.bus_rst)) begin
         nxt = CONN_IDLE;
      end else if (bus_evt[IRQ_BUSRST] || bus_evt[IRQ_DROP]) begin
         nxt = CONN_IDLE;
      end else if (seq_apply && (seq_conn != KEEP)) begin
         nxt = conn_e'(seq_conn);
      end else if (bus_evt[IRQ_RESEL]) begin
         nxt = CONN_INIT;
      end else if (bus_evt[IRQ_SEL] || bus_evt[IRQ_SELA]) begin
         nxt = CONN_TGT;
      end else if (fire && cls.drop) begin
         nxt = CONN_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conn <= CONN_IDLE;
      end else begin
         conn <= nxt;
      end
   end

endmodule

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
   import scd_pkg::*;
#(
   parameter int CMD_W          = 8,
   parameter int IRQ_W          = 8,
   parameter int PHASE_W        = 3,
   parameter bit QUIET_SUPPRESS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic [CMD_W-1:0]   cmd_data,
   input  logic               cfg_rst_irq_off,
   input  logic [PHASE_W-1:0] phase_in,
   input  logic [IRQ_W-1:0]   bus_evt,
   input  logic               seq_done,
   input  logic [1:0]         seq_conn,
   input  logic               isr_rd,
   output logic               start,
   output logic [CMD_W-2:0]   op_code,
   output logic               op_dma,
   output logic [1:0]         conn,
   output logic [IRQ_W-1:0]   isr_q,
   output logic [IRQ_W-1:0]   stat_q
);

   localparam int OP_W  = CMD_W - 1;
   localparam int PAD_W = IRQ_W - 1 - PHASE_W;
   localparam logic [IRQ_W-1:0] EVT_MASK =
      ~((IRQ_W'(1) << IRQ_BADCMD) | (IRQ_W'(1) << IRQ_DONE));

   if (CMD_W != 8)   begin : g_bad_cmd   $error("CMD_W must be 8");   end
   if (IRQ_W != 8)   begin : g_bad_irq   $error("IRQ_W must be 8");   end
   if (PHASE_W != 3) begin : g_bad_phase $error("PHASE_W must be 3"); end

   cmd_class_t       cls;
   conn_e            conn_s;
   logic             fire;
   logic             busy_q;
   logic             quiet_q;
   logic             seq_apply;
   logic             done_irq;
   logic [IRQ_W-1:0] set_vec;

   scd_classify #(.OP_W(OP_W)) u_cls (
      .conn (conn_s),
      .opc  (cmd_data[OP_W-1:0]),
      .cls  (cls)
   );

   assign fire      = cmd_wr & cls.legal;
   assign seq_apply = seq_done & busy_q;

   if (QUIET_SUPPRESS) begin : g_quiet
      assign done_irq = seq_apply & ~quiet_q;
   end else begin : g_loud
      assign done_irq = seq_apply;
   end

   always_comb begin
      set_vec             = bus_evt & EVT_MASK;
      set_vec[IRQ_BUSRST] = (bus_evt[IRQ_BUSRST] | (fire & cls.bus_rst))
                          & ~cfg_rst_irq_off;
      set_vec[IRQ_BADCMD] = cmd_wr & ~cls.legal;
      set_vec[IRQ_DONE]   = done_irq;
   end

   scd_isr #(.W(IRQ_W)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (fire & cls.chip_rst),
      .rd      (isr_rd),
      .set_vec (set_vec),
      .q       (isr_q)
   );

   scd_conn #(.EVT_W(IRQ_W)) u_conn (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .cls       (cls),
      .bus_evt   (bus_evt),
      .seq_apply (seq_apply),
      .seq_conn  (seq_conn),
      .conn      (conn_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         quiet_q <= 1'b0;
         start   <= 1'b0;
         op_code <= '0;
         op_dma  <= 1'b0;
      end else begin
         start <= fire;
         if (fire) begin
            op_code <= cmd_data[OP_W-1:0];
            op_dma  <= cmd_data[CMD_W-1];
            quiet_q <= cls.quiet;
            busy_q  <= ~cls.chip_rst;
         end else if (seq_apply) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign conn   = conn_s;
   assign stat_q = {|isr_q, {PAD_W{1'b0}}, phase_in};

endmodule

// File: rtl/scd_chk.sv
module scd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic [7:0] cmd_data,
   input logic       bus_evt_any,
   input logic       seq_done,
   input logic       isr_rd,
   input logic       start,
   input logic [1:0] conn,
   input logic [7:0] isr_q,
   input logic [7:0] stat_q
);

   // R3
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(cmd_wr));

   // R4
   bad_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q[6]) |-> !start);

   // R6
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_rd && !cmd_wr && !bus_evt_any && !seq_done) |=> (isr_q == 8'h00 && !stat_q[7]));

   // R9
   chiprst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_data[6:0] == 7'h02) |=> (conn == 2'd0 && isr_q == 8'h00));

   // R7
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q[3]) |-> $past(seq_done));

   // R2
   conn_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conn != 2'd3);

endmodule

bind scsi_cmd_decoder scd_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_wr      (cmd_wr),
   .cmd_data    (cmd_data),
   .bus_evt_any (|bus_evt),
   .seq_done    (seq_done),
   .isr_rd      (isr_rd),
   .start       (start),
   .conn        (conn),
   .isr_q       (isr_q),
   .stat_q      (stat_q)
);

// File: tb/sim_scsi_cmd_decoder.sv
module sim_scsi_cmd_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_data = 8'h00;
   logic       cfg_rst_irq_off = 1'b0;
   logic [2:0] phase_in = 3'b000;
   logic [7:0] bus_evt = 8'h00;
   logic       seq_done = 1'b0;
   logic [1:0] seq_conn = 2'd3;
   logic       isr_rd = 1'b0;
   logic       start;
   logic [6:0] op_code;
   logic       op_dma;
   logic [1:0] conn;
   logic [7:0] isr_q;
   logic [7:0] stat_q;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   scsi_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .cfg_rst_irq_off(cfg_rst_irq_off), .phase_in(phase_in), .bus_evt(bus_evt),
      .seq_done(seq_done), .seq_conn(seq_conn), .isr_rd(isr_rd),
      .start(start), .op_code(op_code), .op_dma(op_dma), .conn(conn),
      .isr_q(isr_q), .stat_q(stat_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic evt(input logic [7:0] v);
      bus_evt = v;
      @(negedge clk);
      bus_evt = 8'h00;
   endtask

   task automatic cmd(input logic [7:0] v);
      cmd_wr = 1'b1;
      cmd_data = v;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      isr_rd = 1'b1;
      v = isr_q;
      @(negedge clk);
      isr_rd = 1'b0;
   endtask

   task automatic done(input logic [1:0] c);
      seq_done = 1'b1;
      seq_conn = c;
      @(negedge clk);
      seq_done = 1'b0;
      seq_conn = 2'd3;
   endtask

   function automatic bit legal_f(input int st, input int op);
      if (op <= 3) return 1'b1;
      if (st == 0) return (op >= 'h40 && op <= 'h46);
      if (st == 1) return (op == 'h10 || op == 'h11 || op == 'h12 ||
                           op == 'h18 || op == 'h1A || op == 'h1B);
      return (op == 'h27);
   endfunction

   function automatic bit quiet_f(input int op);
      return (op <= 3 || op == 'h44 || op == 'h1A || op == 'h1B || op == 'h27);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] junk;
      logic [7:0] got;
      logic [7:0] d;
      logic [7:0] exp_isr;
      int         exp_conn;
      bit         lg;
      bit         off;
      string      tag;

      do_reset();
      // R1
      chk("R1 conn", conn, 0);
      chk("R1 isr", isr_q, 0);
      chk("R1 pend", stat_q[7], 0);
      chk("R1 start", start, 0);

      // R2 R3 R4 R8 R9 R10 sweep
      for (int st = 0; st < 3; st++) begin
         for (int op = 0; op < 128; op++) begin
            do_reset();
            off = op[1] ^ st[0];
            cfg_rst_irq_off = off;
            if (st == 1) evt(8'h04);
            if (st == 2) evt(8'h01);
            rd(junk);
            chk("R5 setup", conn, st);
            d = {op[0] ^ op[3], op[6:0]};
            cmd(d);
            lg = legal_f(st, op);
            if (!lg) exp_isr = 8'h40;
            else if (op == 3 && !off) exp_isr = 8'h80;
            else exp_isr = 8'h00;
            if (lg && (op == 2 || op == 3 || op == 'h27)) exp_conn = 0;
            else exp_conn = st;
            if (!lg) tag = "R4";
            else if (op == 2) tag = "R9";
            else if (op == 3) tag = "R8";
            else if (op == 'h27) tag = "R10";
            else tag = "R2";
            chk({tag, " start"}, start, lg);
            chk({tag, " isr"}, isr_q, exp_isr);
            chk({tag, " conn"}, conn, exp_conn);
            chk({tag, " pend"}, stat_q[7], exp_isr != 0);
            if (lg) begin
               chk("R3 op_code", op_code, op);
               chk("R3 op_dma", op_dma, d[7]);
            end
            @(negedge clk);
            chk("R3 width", start, 0);
            if (lg) begin
               done(2'd3);
               if (op != 2 && !quiet_f(op)) exp_isr = exp_isr | 8'h08;
               chk("R7 quiet", isr_q, exp_isr);
               chk("R7 keep", conn, exp_conn);
            end
         end
      end
      cfg_rst_irq_off = 1'b0;

      // R11
      do_reset();
      phase_in = 3'b101;
      @(negedge clk);
      chk("R11 stat", stat_q, 8'h05);
      phase_in = 3'b010;
      @(negedge clk);
      chk("R11 stat", stat_q, 8'h02);

      // R5 ignored event bits
      evt(8'h48);
      chk("R5 ignored isr", isr_q, 0);
      chk("R5 ignored conn", conn, 0);

      // R7 completion with nothing outstanding
      done(2'd1);
      chk("R7 idle done isr", isr_q, 0);
      chk("R7 idle done conn", conn, 0);

      // R7 completion updates state
      cmd(8'hC2);
      done(2'd1);
      chk("R7 done conn", conn, 1);
      chk("R7 done isr", isr_q, 8'h08);

      // R6 read colliding with a new cause
      isr_rd = 1'b1;
      bus_evt = 8'h10;
      got = isr_q;
      @(negedge clk);
      isr_rd = 1'b0;
      bus_evt = 8'h00;
      chk("R6 read value", got, 8'h08);
      chk("R6 collide isr", isr_q, 8'h10);
      chk("R6 collide pend", stat_q[7], 1);
      rd(got);
      chk("R6 read value", got, 8'h10);
      chk("R6 clear isr", isr_q, 0);
      chk("R6 clear pend", stat_q[7], 0);

      // R5 disconnect event
      evt(8'h20);
      chk("R5 drop conn", conn, 0);
      chk("R5 drop isr", isr_q, 8'h20);
      rd(junk);

      // R5 bus reset event, masked then unmasked
      evt(8'h02);
      chk("R5 selatn conn", conn, 2);
      rd(junk);
      cfg_rst_irq_off = 1'b1;
      evt(8'h80);
      chk("R5 masked rst isr", isr_q, 0);
      chk("R5 masked rst conn", conn, 0);
      cfg_rst_irq_off = 1'b0;
      evt(8'h80);
      chk("R5 rst isr", isr_q, 8'h80);

      // R9 chip reset clears pending causes
      evt(8'h10);
      cmd(8'h02);
      chk("R9 clear isr", isr_q, 0);
      chk("R9 clear conn", conn, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule